// File: doc/BRIEF.md
# Address Parity Error Injector

This block sits beside the address parity generator of an internal bus and lets test software force a single, controlled address parity error. It computes one even-parity bit per address byte. Software programs a 32-bit control word that holds an arm flag, the initiator ID to target and a per-bit corruption mask.

While the block is armed, it watches every address-phase strobe. The first phase whose initiator ID equals the programmed ID has the mask XORed into its generated parity bits. The arm flag then drops by itself on the next clock edge, so the corruption hits exactly one transaction. Phases from other initiators pass through untouched and leave the block armed. Software can poll the arm flag through the read port to see that the injection has happened.

Top module: `addr_par_inject`

## Requirements
- R1: After a synchronous active-low reset, the control word reads as 0x00000000.
- R2: A register write stores the arm flag at bit 0, the target ID at bits 7:4 and the mask at bits 20:16. Bits 31:21 and 3:1 always read as zero, so writing 0xFFFFFFFF reads back as 0x001F00F1.
- R3: When no injection takes place, parity bit i is the XOR of address bits 8i+7..8i (even parity), for i = 0..4. A cycle without a strobe counts as no injection.
- R4: In a strobed phase in which the block is armed and the initiator ID equals the target ID, the parity output equals the true parity XOR the mask, where mask bit 16+i acts on parity bit i. The corrupted value appears in the same cycle as the strobe.
- R5: The arm flag clears on the clock edge that ends the injecting phase, so the read port shows bit 0 as 0 from the next cycle.
- R6: A strobed phase whose initiator ID differs from the target ID gets true parity and leaves the arm flag set.
- R7: Matching phases that follow the injecting one get true parity until software arms the block again.
- R8: When a register write and a hardware clear fall in the same cycle, the written value is what gets stored. The phase in that cycle still uses the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| ap_valid | input | 1 | Address-phase strobe |
| ap_init_id | input | 4 | Initiator ID of the current phase |
| ap_addr | input | 40 | Address of the current phase |
| ap_parity | output | 5 | Driven address parity, one bit per byte |

## Verification
A wrong arm state shows up in one of two ways. The parity of the next matching strobe comes out wrong in the same cycle, or the arm bit on the read port is wrong one cycle after the phase. The bench therefore checks both ports around every matching and non-matching phase. A mask applied to the wrong parity lane is visible at once, because asymmetric masks are used against addresses whose bytes have mixed parities. The same-cycle collision of a write and a clear is checked through the stored word and through the two phases that follow it.

// File: rtl/apinj_pkg.sv
// Shared constants of the address parity error injector.
// Assumes a 32-bit control word; field offsets are fixed by software use.
package apinj_pkg;
    localparam int REG_W    = 32;
    localparam int EN_BIT   = 0;
    localparam int ID_LSB   = 4;
    localparam int MASK_LSB = 16;
endpackage

// File: rtl/apinj_ctrl_reg.sv
// Control word of the injector: arm flag, target ID and parity mask.
// Assumes a single write strobe; a write beats the hardware clear.
module apinj_ctrl_reg
    import apinj_pkg::*;
#(
    parameter int ID_W = 4,
    parameter int NPAR = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             hw_clr,
    output logic             armed,
    output logic [ID_W-1:0]  tgt_id,
    output logic [NPAR-1:0]  mask,
    output logic [REG_W-1:0] rdata
);
    // Store the fields; a write takes priority over the self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            tgt_id <= '0;
            mask   <= '0;
        end else if (wr) begin
            armed  <= wdata[EN_BIT];
            tgt_id <= wdata[ID_LSB +: ID_W];
            mask   <= wdata[MASK_LSB +: NPAR];
        end else if (hw_clr) begin
            armed  <= 1'b0;
        end
    end

    // Assemble the read word; reserved bits stay zero.
    always_comb begin
        rdata = '0;
        rdata[EN_BIT]             = armed;
        rdata[ID_LSB +: ID_W]     = tgt_id;
        rdata[MASK_LSB +: NPAR]   = mask;
    end

    assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr && !wr) |=> !armed);
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (armed == $past(wdata[EN_BIT])) && (mask == $past(wdata[MASK_LSB +: NPAR])));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !hw_clr) |=> $stable(armed));
endmodule

// File: rtl/apinj_pargen.sv
// Even-parity generator: one bit per address byte.
// Assumes the address width is a whole number of bytes.
module apinj_pargen #(
    parameter int ADDR_W = 40,
    localparam int NPAR  = ADDR_W / 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NPAR-1:0]   par
);
    // One XOR reduction per byte lane.
    for (genvar i = 0; i < NPAR; i++) begin : g_lane
        assign par[i] = ^addr[8*i +: 8];
    end
endmodule

// File: rtl/apinj_corrupt.sv
// Injection datapath: detects a matching armed phase and flips masked bits.
// Assumes the strobe, ID and parity are valid in the same cycle.
module apinj_corrupt #(
    parameter int ID_W = 4,
    parameter int NPAR = 5
) (
    input  logic            valid,
    input  logic [ID_W-1:0] init_id,
    input  logic [ID_W-1:0] tgt_id,
    input  logic            armed,
    input  logic [NPAR-1:0] mask,
    input  logic [NPAR-1:0] par_true,
    output logic [NPAR-1:0] par_out,
    output logic            hit
);
    // Decide whether this phase is the one to corrupt.
    always_comb hit = valid && armed && (init_id == tgt_id);

    // Apply the mask only on a hit.
    always_comb par_out = hit ? (par_true ^ mask) : par_true;
endmodule

// File: rtl/addr_par_inject.sv
// Top of the address parity error injector.
// Assumes one address phase per strobed cycle; parity output is combinational.
module addr_par_inject
    import apinj_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int ID_W   = 4,
    localparam int NPAR  = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ap_valid,
    input  logic [ID_W-1:0]   ap_init_id,
    input  logic [ADDR_W-1:0] ap_addr,
    output logic [NPAR-1:0]   ap_parity
);
    logic            armed;
    logic [ID_W-1:0] tgt_id;
    logic [NPAR-1:0] mask;
    logic [NPAR-1:0] par_true;
    logic            hit;

    apinj_ctrl_reg #(.ID_W(ID_W), .NPAR(NPAR)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .hw_clr(hit), .armed(armed), .tgt_id(tgt_id), .mask(mask),
        .rdata(reg_rdata)
    );

    apinj_pargen #(.ADDR_W(ADDR_W)) u_gen (.addr(ap_addr), .par(par_true));

    apinj_corrupt #(.ID_W(ID_W), .NPAR(NPAR)) u_cor (
        .valid(ap_valid), .init_id(ap_init_id), .tgt_id(tgt_id), .armed(armed),
        .mask(mask), .par_true(par_true), .par_out(ap_parity), .hit(hit)
    );

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[REG_W-1:MASK_LSB+NPAR] == '0) && (reg_rdata[ID_LSB-1:EN_BIT+1] == '0));
    assert_idle_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ap_valid |-> (ap_parity == par_true));
    assert_mismatch_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && ap_init_id != reg_rdata[ID_LSB +: ID_W]) |-> (ap_parity == par_true));
    assert_inject_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && reg_rdata[EN_BIT] && ap_init_id == reg_rdata[ID_LSB +: ID_W])
        |-> ((ap_parity ^ par_true) == reg_rdata[MASK_LSB +: NPAR]));
endmodule

// File: tb/addr_par_inject_tb.sv
module addr_par_inject_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ap_valid = 1'b0;
    logic [3:0]  ap_init_id = '0;
    logic [39:0] ap_addr = '0;
    logic [4:0]  ap_parity;
    int checks = 0;
    int errors = 0;
    logic [4:0] got;

    always #2.5 clk = ~clk;

    addr_par_inject u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ap_valid(ap_valid), .ap_init_id(ap_init_id),
        .ap_addr(ap_addr), .ap_parity(ap_parity)
    );

    typedef struct packed { logic [3:0] id; logic [39:0] addr; } vec_t;
    localparam vec_t VECS [8] = '{
        '{4'h0, 40'h00_00_00_00_00}, '{4'h1, 40'hFF_FF_FF_FF_FF},
        '{4'h2, 40'h01_00_01_00_01}, '{4'h3, 40'h80_03_07_FE_10},
        '{4'h4, 40'h12_34_56_78_9A}, '{4'h5, 40'hA5_5A_C3_3C_01},
        '{4'hF, 40'h7F_01_02_04_08}, '{4'h9, 40'hDE_AD_BE_EF_55}
    };

    // Expected even parity per byte, counted bit by bit.
    function automatic logic [4:0] ref_par(input logic [39:0] a);
        logic [4:0] p = '0;
        for (int b = 0; b < 40; b++) if (a[b]) p[b/8] = ~p[b/8];
        return p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle register write, driven on the falling edge.
    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // One strobed phase; parity captured mid-cycle into got.
    task automatic phase(input logic [3:0] id, input logic [39:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        ap_valid = 1'b1; ap_init_id = id; ap_addr = a; reg_wr = w; reg_wdata = d;
        #1 got = ap_parity;
        @(negedge clk);
        ap_valid = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 reset word", reg_rdata, 32'h0);

        // Table walk: pass-through parity while not armed (R3).
        for (int i = 0; i < 8; i++) begin
            phase(VECS[i].id, VECS[i].addr, 1'b0, '0);
            chk("R3 passthru", {27'b0, got}, {27'b0, ref_par(VECS[i].addr)});
        end

        // Field placement and reserved bits (R2).
        wr_reg(32'hFFFF_FFFF);
        #1 chk("R2 all-ones readback", reg_rdata, 32'h001F_00F1);
        wr_reg(32'h0);
        #1 chk("R2 cleared readback", reg_rdata, 32'h0);

        // Arm for ID 5 with an asymmetric mask.
        wr_reg(32'h0015_0051);
        #1 chk("R2 armed readback", reg_rdata, 32'h0015_0051);
        @(negedge clk); ap_addr = 40'h01_00_01_03_01; #1
        chk("R3 no strobe while armed", {27'b0, ap_parity}, {27'b0, ref_par(40'h01_00_01_03_01)});
        phase(4'h3, 40'h12_34_56_78_9A, 1'b0, '0);
        chk("R6 mismatch parity", {27'b0, got}, {27'b0, ref_par(40'h12_34_56_78_9A)});
        #1 chk("R6 still armed", reg_rdata, 32'h0015_0051);
        phase(4'h5, 40'h12_34_56_78_9A, 1'b0, '0);
        chk("R4 injected parity", {27'b0, got}, {27'b0, ref_par(40'h12_34_56_78_9A) ^ 5'h15});
        #1 chk("R5 arm cleared", reg_rdata, 32'h0015_0050);
        phase(4'h5, 40'h12_34_56_78_9A, 1'b0, '0);
        chk("R7 second match clean", {27'b0, got}, {27'b0, ref_par(40'h12_34_56_78_9A)});
        phase(4'h5, 40'hA5_5A_C3_3C_01, 1'b0, '0);
        chk("R7 third match clean", {27'b0, got}, {27'b0, ref_par(40'hA5_5A_C3_3C_01)});

        // Single-lane mask on the top byte (R4).
        wr_reg(32'h0010_00C1);
        phase(4'hC, 40'h00_00_00_00_00, 1'b0, '0);
        chk("R4 lane4 mask", {27'b0, got}, 32'h10);

        // Write colliding with the self-clear (R8).
        wr_reg(32'h0001_0021);
        phase(4'h2, 40'h7F_01_02_04_08, 1'b1, 32'h0002_0021);
        chk("R8 old mask used", {27'b0, got}, {27'b0, ref_par(40'h7F_01_02_04_08) ^ 5'h01});
        #1 chk("R8 write wins", reg_rdata, 32'h0002_0021);
        phase(4'h2, 40'h7F_01_02_04_08, 1'b0, '0);
        chk("R8 new mask used", {27'b0, got}, {27'b0, ref_par(40'h7F_01_02_04_08) ^ 5'h02});
        #1 chk("R5 cleared after R8", reg_rdata, 32'h0002_0020);

        // Reset mid-use returns the word to zero (R1).
        wr_reg(32'h001F_00F1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R1 reset after arm", reg_rdata, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule